// File: doc/BRIEF.md
# Rotating Register Stack with Fault Detection

This block holds the eight 80-bit operand registers of a stack-oriented floating-point unit. Software-visible operands are named ST(i) and resolve to physical slot (TOP + i) mod 8. TOP is a 3-bit pointer that moves down on a push and up on a pop. Every slot has a valid tag. The block checks each operation against those tags before it changes any state. The data word is opaque, so the arithmetic lives outside the block.

A caller reads ST(0) and ST(i) combinationally in the cycle it presents an operation. If the operation needs a write, the caller supplies the value to store. An add-and-pop sequence works in two steps. The caller reads both operands, computes the sum elsewhere, and issues the add-and-pop operation with that sum. The block then writes ST(i) and retires the old ST(0) in the same edge.

Stack faults are reported three ways. A direction bit (C1) separates an overflow from an underflow. Invalid-operation and stack-fault flags are raised and stay set until reset. A one-cycle strobe marks each faulting operation.

Top module: `fpstk`

## Requirements
- R1: While rst_ni is low and after its release, top_o is 0, every slot is empty and holds zero, and c1_o, ie_o, sf_o and fault_o are 0.
- R2: st0_o shows the data of physical slot TOP. sti_o shows the data of slot (TOP + k) mod 8. Here k is idx_i, except that k is 1 when op_i is add-and-pop and idx_i is 0.
- R3: Push (op_i = 3) on a non-faulting cycle decrements TOP mod 8, stores wdata_i in the new ST(0), marks that slot valid and clears c1_o.
- R4: Pop (op_i = 4) on a non-faulting cycle marks the old ST(0) empty and increments TOP mod 8. It leaves c1_o unchanged.
- R5: Write (op_i = 2) stores wdata_i in ST(idx_i) and marks that slot valid. A write never faults.
- R6: Add-and-pop (op_i = 5) stores wdata_i in ST(k), with k as in R2. It then empties the old ST(0) and increments TOP, so the result appears as the new ST(k-1).
- R7: Read (op_i = 1) and add-and-pop underflow when ST(0) or ST(k) is empty. Pop underflows when ST(0) is empty. On the next edge an underflow clears c1_o and sets ie_o and sf_o.
- R8: A push whose target slot (TOP - 1) mod 8 is already valid overflows. On the next edge it sets c1_o, ie_o and sf_o.
- R9: A faulting operation leaves TOP, the tags and the data unchanged. fault_o is high in exactly the cycle after each faulting operation. A nop (op_i = 0, 6 or 7) changes nothing.
- R10: Once set, ie_o and sf_o stay high through later non-faulting operations until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation: 0 nop, 1 read, 2 write, 3 push, 4 pop, 5 add-and-pop |
| idx_i | input | 3 | Stack-relative operand index i |
| wdata_i | input | 80 | Value for write, push or add-and-pop |
| st0_o | output | 80 | Data of ST(0) |
| sti_o | output | 80 | Data of ST(k) |
| top_o | output | 3 | Current TOP pointer |
| c1_o | output | 1 | Fault direction bit: 1 overflow, 0 underflow |
| ie_o | output | 1 | Sticky invalid-operation flag |
| sf_o | output | 1 | Sticky stack-fault flag |
| fault_o | output | 1 | One-cycle strobe after a faulting operation |

## Verification
The bench builds the block with its defaults: an 80-bit data word and a depth of eight. Because the depth is small, a few pushes fill the ring completely, which brings overflow into reach. TOP wraps from 0 to 7 on the very first push. The random mix of pushes, pops and add-and-pops drives TOP around the ring many times. Along the way it reaches full, empty and partly filled states, and index offsets that cross the wrap point.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_PUSH  = 3'd3,
    OP_POP   = 3'd4,
    OP_ADDP  = 3'd5
  } stk_op_e;
endpackage

// File: rtl/fpstk_regfile.sv
module fpstk_regfile #(
  parameter int DW    = 80,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[g] <= '0;
      else if (we_i && (waddr_i == AW'(g)))   mem_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/fpstk_ctl.sv
module fpstk_ctl
  import fpstk_pkg::*;
#(
  parameter int DEPTH = 8,            // power of two: pointer wraps by overflow
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  stk_op_e       op_i,
  input  logic [AW-1:0] idx_i,
  output logic [AW-1:0] top_o,
  output logic [AW-1:0] p0_o,
  output logic [AW-1:0] pi_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic          fault_now_o,
  output logic          fault_o,
  output logic          c1_o,
  output logic          ie_o,
  output logic          sf_o
);
  logic [AW-1:0]    top_q, top_d, idx_eff, p0, pi, pn;
  logic [DEPTH-1:0] tag_q, tag_d;
  logic             under, over, fault;
  logic             fault_q, c1_q, ie_q, sf_q;

  // add-and-pop with no operand targets ST(1)
  assign idx_eff = (op_i == OP_ADDP && idx_i == '0) ? AW'(1) : idx_i;
  assign p0 = top_q;
  assign pi = top_q + idx_eff;
  assign pn = top_q - AW'(1);

  always_comb begin
    under = 1'b0;
    over  = 1'b0;
    case (op_i)
      OP_READ, OP_ADDP: under = !tag_q[p0] || !tag_q[pi];
      OP_POP:           under = !tag_q[p0];
      OP_PUSH:          over  = tag_q[pn];
      default: ;
    endcase
  end

  assign fault = under | over;

  always_comb begin
    tag_d = tag_q;
    top_d = top_q;
    if (!fault) begin
      case (op_i)
        OP_PUSH:  begin tag_d[pn] = 1'b1; top_d = pn; end
        OP_WRITE: tag_d[pi] = 1'b1;
        OP_POP:   begin tag_d[p0] = 1'b0; top_d = top_q + AW'(1); end
        OP_ADDP:  begin tag_d[pi] = 1'b1; tag_d[p0] = 1'b0; top_d = top_q + AW'(1); end
        default: ;
      endcase
    end
  end

  assign we_o    = !fault && (op_i == OP_PUSH || op_i == OP_WRITE || op_i == OP_ADDP);
  assign waddr_o = (op_i == OP_PUSH) ? pn : pi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q   <= '0;
      tag_q   <= '0;
      fault_q <= 1'b0;
      c1_q    <= 1'b0;
      ie_q    <= 1'b0;
      sf_q    <= 1'b0;
    end else begin
      top_q   <= top_d;
      tag_q   <= tag_d;
      fault_q <= fault;
      if (under) begin
        c1_q <= 1'b0; ie_q <= 1'b1; sf_q <= 1'b1;
      end else if (over) begin
        c1_q <= 1'b1; ie_q <= 1'b1; sf_q <= 1'b1;
      end else if (op_i == OP_PUSH) begin
        c1_q <= 1'b0;
      end
    end
  end

  assign top_o       = top_q;
  assign p0_o        = p0;
  assign pi_o        = pi;
  assign fault_now_o = fault;
  assign fault_o     = fault_q;
  assign c1_o        = c1_q;
  assign ie_o        = ie_q;
  assign sf_o        = sf_q;

  // R9
  fault_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> (top_q == $past(top_q)) && (tag_q == $past(tag_q)) && fault_o);
  // R3
  push_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PUSH && !fault) |=> (top_q == $past(top_q) - AW'(1)) && !c1_o);
  // R4
  pop_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_POP && !fault) |=> (top_q == $past(top_q) + AW'(1))
      && ($countones(tag_q) == $countones($past(tag_q)) - 1));
  // R8
  overflow_c1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PUSH && fault) |=> c1_o && ie_o && sf_o);
  // R7
  underflow_c1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault && op_i != OP_PUSH) |=> !c1_o && ie_o && sf_o);
  // R10
  sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ie_o) |-> ie_o && sf_o);
endmodule

// File: rtl/fpstk.sv
module fpstk
  import fpstk_pkg::*;
#(
  parameter int DW    = 80,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] st0_o,
  output logic [DW-1:0] sti_o,
  output logic [AW-1:0] top_o,
  output logic          c1_o,
  output logic          ie_o,
  output logic          sf_o,
  output logic          fault_o
);
  stk_op_e       op;
  logic [AW-1:0] p0, pi, waddr;
  logic          we, fault_now;

  assign op = stk_op_e'(op_i);

  fpstk_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk_i, .rst_ni,
    .op_i        (op),
    .idx_i,
    .top_o,
    .p0_o        (p0),
    .pi_o        (pi),
    .we_o        (we),
    .waddr_o     (waddr),
    .fault_now_o (fault_now),
    .fault_o,
    .c1_o, .ie_o, .sf_o
  );

  fpstk_regfile #(.DW(DW), .DEPTH(DEPTH)) u_rf (
    .clk_i, .rst_ni,
    .we_i      (we),
    .waddr_i   (waddr),
    .wdata_i,
    .raddr_a_i (p0),
    .raddr_b_i (pi),
    .rdata_a_o (st0_o),
    .rdata_b_o (sti_o)
  );

  // R3
  push_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_PUSH && !fault_now) |=> st0_o == $past(wdata_i));
  // R5
  write_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_WRITE) |-> !fault_now);
endmodule

// File: tb/fpstk_tb.sv
`timescale 1ns/1ps
module fpstk_tb;
  localparam int DW = 80;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    op_i = '0;
  logic [2:0]    idx_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] st0_o, sti_o;
  logic [2:0]    top_o;
  logic          c1_o, ie_o, sf_o, fault_o;

  int checks = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_reg [DEPTH];
  logic          m_tag [DEPTH];
  logic [2:0]    m_top;
  logic          m_c1, m_ie, m_sf, m_fault;

  always #4 clk = ~clk;

  fpstk #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni, .op_i, .idx_i, .wdata_i,
    .st0_o, .sti_o, .top_o, .c1_o, .ie_o, .sf_o, .fault_o
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] eff_idx(input logic [2:0] op, input logic [2:0] idx);
    return (op == 3'd5 && idx == 3'd0) ? 3'd1 : idx;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin m_reg[i] = '0; m_tag[i] = 1'b0; end
    m_top = '0; m_c1 = 0; m_ie = 0; m_sf = 0; m_fault = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; op_i = '0;
    model_reset();
    #1;
    chk("R1 top", DW'(top_o), '0);
    chk("R1 flags", DW'({c1_o, ie_o, sf_o, fault_o}), '0);
    chk("R1 data", st0_o, '0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic do_op(input logic [2:0] op, input logic [2:0] idx, input logic [DW-1:0] d);
    logic [2:0] k, p0, pi, pn;
    logic under, over;
    string tag;
    @(negedge clk);
    op_i = op; idx_i = idx; wdata_i = d;
    #1;
    k  = eff_idx(op, idx);
    p0 = m_top; pi = m_top + k; pn = m_top - 3'd1;
    chk("R2 st0", st0_o, m_reg[p0]);
    chk("R2 sti", sti_o, m_reg[pi]);
    under = 0; over = 0;
    case (op)
      3'd1, 3'd5: under = !m_tag[p0] || !m_tag[pi];
      3'd4:       under = !m_tag[p0];
      3'd3:       over  = m_tag[pn];
      default: ;
    endcase
    tag = "R9";
    if (under) begin
      m_c1 = 0; m_ie = 1; m_sf = 1; tag = "R7";
    end else if (over) begin
      m_c1 = 1; m_ie = 1; m_sf = 1; tag = "R8";
    end else begin
      case (op)
        3'd2: begin m_reg[pi] = d; m_tag[pi] = 1; tag = "R5"; end
        3'd3: begin m_reg[pn] = d; m_tag[pn] = 1; m_top = pn; m_c1 = 0; tag = "R3"; end
        3'd4: begin m_tag[p0] = 0; m_top = m_top + 3'd1; tag = "R4"; end
        3'd5: begin m_reg[pi] = d; m_tag[pi] = 1; m_tag[p0] = 0; m_top = m_top + 3'd1; tag = "R6"; end
        default: tag = m_ie ? "R10" : "R9";
      endcase
    end
    m_fault = under | over;
    @(posedge clk);
    #2;
    chk({tag, " top"},   DW'(top_o),   DW'(m_top));
    chk({tag, " c1"},    DW'(c1_o),    DW'(m_c1));
    chk({tag, " ie"},    DW'(ie_o),    DW'(m_ie));
    chk({tag, " sf"},    DW'(sf_o),    DW'(m_sf));
    chk({tag, " fault"}, DW'(fault_o), DW'(m_fault));
    chk({tag, " st0"},   st0_o,        m_reg[m_top]);
  endtask

  function automatic logic [DW-1:0] rnd_data();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    void'($urandom(32'hC0FFEE));
    model_reset();
    do_reset();
    do_op(3'd1, 3'd0, '0);                      // R7 read of empty stack
    do_op(3'd0, 3'd0, '0);                      // R9 strobe drops
    do_reset();
    do_op(3'd4, 3'd0, '0);                      // R7 pop of empty
    do_reset();
    for (int i = 0; i < DEPTH; i++) do_op(3'd3, 3'd0, DW'(i + 100)); // R3 fill, TOP wraps
    for (int i = 0; i < DEPTH; i++) do_op(3'd1, 3'(i), '0);          // R2 every offset
    do_op(3'd3, 3'd0, 80'hDEAD);                // R8 overflow, nothing changes
    do_op(3'd1, 3'd7, '0);                      // R9 contents intact
    do_op(3'd5, 3'd0, 80'hABCD);                // R6 default target ST(1)
    do_op(3'd1, 3'd0, '0);                      // R6 result now ST(0)
    do_op(3'd3, 3'd0, 80'h5);                   // R3 push clears C1
    do_op(3'd2, 3'd3, 80'h77);                  // R5 write
    do_op(3'd5, 3'd6, 80'h99);                  // R6 explicit index
    for (int i = 0; i < DEPTH; i++) do_op(3'd4, 3'd0, '0);           // R4 drain then R7
    do_op(3'd5, 3'd2, 80'h1);                   // R7 add-and-pop underflow
    do_op(3'd0, 3'd0, '0);                      // R10 flags stay
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [2:0] op;
      r = int'($urandom() % 10);
      case (r)
        0, 1, 2: op = 3'd3;
        3, 4:    op = 3'd4;
        5:       op = 3'd1;
        6:       op = 3'd2;
        7:       op = 3'd5;
        8:       op = 3'd0;
        default: op = 3'd7;
      endcase
      do_op(op, 3'($urandom()), rnd_data());
      if (n == 1500) do_reset();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, miscompares);
      $finish;
    end
  end
endmodule